// File: doc/BRIEF.md
# Dual Loop Code Detector

This block watches a received T1 serial stream and reports whether either of two programmable repeating patterns is present. One pattern is the loop-up code and the other is the loop-down code. Each code is held in its own 8-bit definition and has its own length of 1 to 8 bits. The block has no knowledge of where the pattern starts in the stream. Each detector therefore compares every accepted bit against the bit that arrived one code length earlier, and counts the disagreements over a fixed window. At the end of the window it also checks that the most recent code-length run of bits is some rotation of the programmed code.

A window holds `WINDOW_BITS` bit enables. The default is 74112, which is 48 ms at 1.544 Mb/s. A detector hits when its mismatch count stays below one fiftieth of the window length. Bits in framing slots, marked by `fSlot`, still count toward the window. They are not compared and do not enter the history, so the block works on framed and unframed streams alike. A hit sets a sticky status bit that stays set until the host pulses `clrStatus`. Any change to a code definition or to the length field restarts the window.

Top module: `loopCodeDetect`

## Requirements
- R1: After reset, `loopUp` and `loopDown` are 0.
- R2: In `lenCtl`, bits [5:3] select the loop-up length and bits [2:0] select the loop-down length. A field value n means a code of n+1 bits. The code is taken from definition bits 7 down to 8-(n+1), and bit 7 is sent first.
- R3: A decision is made on the `WINDOW_BITS`-th cycle with `bitEn` high since the last window end or restart, and framing slots are included in that count. The status output shows the result from the next clock edge onward, and never changes in any other cycle except through a clear.
- R4: Detection does not depend on the phase at which the repeating code starts in the stream.
- R5: A mismatch is an accepted bit that differs from the accepted bit one code length earlier. A window with fewer than `WINDOW_BITS/50` mismatches, whose last code-length bits are a rotation of the code, sets the status bit.
- R6: A window with `WINDOW_BITS/50` or more mismatches does not set the status bit.
- R7: A stream that repeats with the code's period but is not a rotation of the code (for example, all zeros against a code containing a one) does not set the status bit.
- R8: A bit presented with `fSlot` high is neither compared nor stored, so periodic framing slots carrying arbitrary values do not prevent detection.
- R9: A set status bit stays set until a cycle with `clrStatus` high clears it.
- R10: A change to `upCode`, `downCode` or `lenCtl` restarts the window count and the mismatch counts, and clears the bit history.
- R11: The two detectors act independently. A stream carrying one code sets only that code's status bit.
- R12: Cycles with `bitEn` low neither count toward the window nor change the history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxData | input | 1 | Received serial bit |
| bitEn | input | 1 | Qualifies `rxData` in this cycle |
| fSlot | input | 1 | Marks the current bit as a framing slot |
| upCode | input | 8 | Loop-up code definition, MSB first |
| downCode | input | 8 | Loop-down code definition, MSB first |
| lenCtl | input | 6 | [5:3] loop-up length code, [2:0] loop-down length code |
| clrStatus | input | 1 | Clears both status bits |
| loopUp | output | 1 | Sticky loop-up detected status |
| loopDown | output | 1 | Sticky loop-down detected status |

## Verification
The only results are the status bits. Each one changes on the clock edge that samples the last bit of a window, and one cycle after a clear. The driver applies every bit at a falling edge. Once the final bit of a window has been taken and the next falling edge is reached, it queues the expected pair. The monitor compares that pair at once, while no edge can disturb the outputs. One check lands one bit before a window end that follows a restart, and another lands exactly at that end. Together they confirm both the restart and the full count.

// File: rtl/lcdPkg.sv
package lcdPkg;
  // Strobes the control section hands to the datapath every cycle.
  typedef struct packed {
    logic bitTake;  // accepted data bit: enabled, not a framing slot, no restart
    logic winEnd;   // last bit of the integration window
    logic restart;  // configuration changed: drop all accumulated state
  } lcdStrobe_t;

  localparam int CODE_W = 8;
  localparam int LEN_W  = 3;
endpackage

// File: rtl/lcdCtrl.sv
module lcdCtrl
  import lcdPkg::*;
#(
  parameter int WINDOW_BITS = 74112,
  parameter int CFG_W = 22
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            bitEn,
  input  logic                            fSlot,
  input  logic [CFG_W-1:0]                cfgWord,
  output lcdStrobe_t                      strb,
  output logic [$clog2(WINDOW_BITS)-1:0]  winCnt
);
  localparam int CNT_W = $clog2(WINDOW_BITS);
  localparam logic [CNT_W-1:0] WIN_LAST = CNT_W'(WINDOW_BITS - 1);

  logic [CFG_W-1:0] cfgQ;
  logic             cfgMoved;

  assign cfgMoved     = (cfgWord != cfgQ);
  assign strb.restart = cfgMoved;
  assign strb.winEnd  = bitEn & ~cfgMoved & (winCnt == WIN_LAST);
  assign strb.bitTake = bitEn & ~fSlot & ~cfgMoved;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ   <= '0;
      winCnt <= '0;
    end else begin
      cfgQ <= cfgWord;
      if (cfgMoved) begin
        winCnt <= '0;
      end else if (bitEn) begin
        winCnt <= strb.winEnd ? '0 : winCnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/lcdChannel.sv
module lcdChannel
  import lcdPkg::*;
#(
  parameter int WINDOW_BITS = 74112
) (
  input  logic              clk,
  input  logic              rstN,
  input  lcdStrobe_t        strb,
  input  logic              rxBit,
  input  logic [CODE_W-1:0] codeDef,
  input  logic [LEN_W-1:0]  lenSel,
  output logic              hit
);
  localparam int MC_W = $clog2(WINDOW_BITS + 1);
  localparam logic [MC_W-1:0] ERR_LIM = MC_W'(WINDOW_BITS / 50);

  logic [CODE_W-1:0] hist, histNext, histEval;
  logic [3:0]        fill, fillInc, fillEval;
  logic [MC_W-1:0]   missCnt, missNext;
  logic              filled, miss, rotOk;
  logic [3:0]        codeLen;
  logic [15:0]       patW, maskW, recentW, rotW;
  logic [3:0]        backShift;

  assign codeLen  = {1'b0, lenSel} + 4'd1;
  assign histNext = {hist[CODE_W-2:0], rxBit};
  assign fillInc  = (fill == 4'd8) ? fill : fill + 4'd1;
  assign filled   = (fill > {1'b0, lenSel});
  assign miss     = strb.bitTake & filled & (rxBit != hist[lenSel]);
  assign missNext = missCnt + MC_W'(miss);

  assign histEval = strb.bitTake ? histNext : hist;
  assign fillEval = strb.bitTake ? fillInc : fill;

  // Code right-aligned, first-sent bit at position codeLen-1.
  assign maskW   = (16'd1 << codeLen) - 16'd1;
  assign patW    = {8'd0, codeDef} >> (4'd8 - codeLen);
  assign recentW = {8'd0, histEval} & maskW;

  always_comb begin
    rotOk = 1'b0;
    rotW = '0;
    backShift = '0;
    for (int r = 0; r < CODE_W; r++) begin
      backShift = codeLen - 4'(r);
      rotW = ((patW << r) | (patW >> backShift)) & maskW;
      if ((4'(r) < codeLen) && (rotW == recentW)) rotOk = 1'b1;
    end
  end

  assign hit = rotOk & (fillEval > {1'b0, lenSel}) & (missNext < ERR_LIM);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist    <= '0;
      fill    <= '0;
      missCnt <= '0;
    end else if (strb.restart) begin
      hist    <= '0;
      fill    <= '0;
      missCnt <= '0;
    end else begin
      missCnt <= strb.winEnd ? '0 : missNext;
      if (strb.bitTake) begin
        hist <= histNext;
        fill <= fillInc;
      end
    end
  end
endmodule

// File: rtl/lcdDatapath.sv
module lcdDatapath
  import lcdPkg::*;
#(
  parameter int WINDOW_BITS = 74112,
  parameter int NUM_CODES = 2
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  lcdStrobe_t                            strb,
  input  logic                                  rxData,
  input  logic                                  clrStatus,
  input  logic [NUM_CODES-1:0][CODE_W-1:0]      codeDefs,
  input  logic [NUM_CODES-1:0][LEN_W-1:0]       lenSels,
  output logic [NUM_CODES-1:0]                  status
);
  logic [NUM_CODES-1:0] hitVec;

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_chan
    lcdChannel #(.WINDOW_BITS(WINDOW_BITS)) u_chan (
      .clk     (clk),
      .rstN    (rstN),
      .strb    (strb),
      .rxBit   (rxData),
      .codeDef (codeDefs[g]),
      .lenSel  (lenSels[g]),
      .hit     (hitVec[g])
    );
  end

  // A hit arriving with a clear still sets the bit.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) status <= '0;
    else status <= (status & ~{NUM_CODES{clrStatus}}) | (hitVec & {NUM_CODES{strb.winEnd}});
  end
endmodule

// File: rtl/loopCodeDetect.sv
module loopCodeDetect
  import lcdPkg::*;
#(
  parameter int WINDOW_BITS = 74112
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxData,
  input  logic       bitEn,
  input  logic       fSlot,
  input  logic [7:0] upCode,
  input  logic [7:0] downCode,
  input  logic [5:0] lenCtl,
  input  logic       clrStatus,
  output logic       loopUp,
  output logic       loopDown
);
  localparam int CNT_W = $clog2(WINDOW_BITS);
  localparam int CFG_W = 2 * CODE_W + 2 * LEN_W;

  lcdStrobe_t              strb;
  logic [CNT_W-1:0]        winCnt;
  logic [1:0]              status;
  logic [1:0][CODE_W-1:0]  codeDefs;
  logic [1:0][LEN_W-1:0]   lenSels;

  assign codeDefs = {downCode, upCode};
  assign lenSels  = {lenCtl[2:0], lenCtl[5:3]};

  lcdCtrl #(.WINDOW_BITS(WINDOW_BITS), .CFG_W(CFG_W)) u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .bitEn   (bitEn),
    .fSlot   (fSlot),
    .cfgWord ({upCode, downCode, lenCtl}),
    .strb    (strb),
    .winCnt  (winCnt)
  );

  lcdDatapath #(.WINDOW_BITS(WINDOW_BITS), .NUM_CODES(2)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .rxData    (rxData),
    .clrStatus (clrStatus),
    .codeDefs  (codeDefs),
    .lenSels   (lenSels),
    .status    (status)
  );

  assign loopUp   = status[0];
  assign loopDown = status[1];
endmodule

// File: rtl/lcdChecker.sv
module lcdChecker #(
  parameter int WINDOW_BITS = 74112
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           clrStatus,
  input logic                           loopUp,
  input logic                           loopDown,
  input logic                           winEnd,
  input logic [$clog2(WINDOW_BITS)-1:0] winCnt
);
  localparam int CNT_W = $clog2(WINDOW_BITS);
  localparam logic [CNT_W-1:0] WIN_LAST = CNT_W'(WINDOW_BITS - 1);

  p_up_only_at_window_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!loopUp && !winEnd) |=> !loopUp);
  p_dn_only_at_window_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!loopDown && !winEnd) |=> !loopDown);
  p_up_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (loopUp && !clrStatus) |=> loopUp);
  p_dn_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (loopDown && !clrStatus) |=> loopDown);
  p_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (clrStatus && !winEnd) |=> (!loopUp && !loopDown));
  p_window_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    winCnt <= WIN_LAST);
endmodule

bind loopCodeDetect lcdChecker #(.WINDOW_BITS(WINDOW_BITS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .clrStatus (clrStatus),
  .loopUp    (loopUp),
  .loopDown  (loopDown),
  .winEnd    (strb.winEnd),
  .winCnt    (winCnt)
);

// File: tb/sim_loopCodeDetect.sv
module sim_loopCodeDetect;
  localparam int PERIOD = 10;
  localparam int WIN = 500;

  typedef struct {
    logic  up;
    logic  dn;
    string tag;
  } expItem_t;

  logic clk = 0, rstN = 0;
  logic rxData = 0, bitEn = 0, fSlot = 0, clrStatus = 0;
  logic [7:0] upCode = 8'h80, downCode = 8'h80;
  logic [5:0] lenCtl = {3'd4, 3'd2};
  logic loopUp, loopDown;

  int checks = 0, errors = 0;
  bit finished = 0;
  expItem_t expQ[$];

  // Stream source: definition, length in bits, starting phase.
  logic [7:0] srcDef;
  int srcLen, srcOff;

  always #(PERIOD/2) clk = ~clk;

  loopCodeDetect #(.WINDOW_BITS(WIN)) u0 (
    .clk(clk), .rstN(rstN), .rxData(rxData), .bitEn(bitEn), .fSlot(fSlot),
    .upCode(upCode), .downCode(downCode), .lenCtl(lenCtl),
    .clrStatus(clrStatus), .loopUp(loopUp), .loopDown(loopDown)
  );

  // Monitor: pops each expectation and compares against the outputs.
  initial begin
    forever begin
      expItem_t it;
      wait (expQ.size() != 0);
      it = expQ.pop_front();
      checks++;
      if (loopUp !== it.up || loopDown !== it.dn) begin
        errors++;
        $display("FAIL %s: got up=%b dn=%b expected up=%b dn=%b",
                 it.tag, loopUp, loopDown, it.up, it.dn);
      end
    end
  end

  task automatic expect2(input logic up, input logic dn, input string tag);
    expItem_t it;
    it.up = up; it.dn = dn; it.tag = tag;
    expQ.push_back(it);
    wait (expQ.size() == 0);
  endtask

  // kind: 0 source pattern, 1 all zeros, 2 all ones
  task automatic driveBits(input int nBits, input int startIdx, input int errCount,
                           input bit framed, input bit gaps, input int kind);
    int idx = startIdx;
    for (int i = 0; i < nBits; i++) begin
      @(negedge clk);
      if (gaps && (i % 3 == 0)) begin
        bitEn = 0;
        rxData = ~rxData;
        @(negedge clk);
      end
      bitEn = 1;
      if (framed && (i % 193 == 0)) begin
        fSlot = 1;
        rxData = 1'($urandom_range(0, 1));
      end else begin
        fSlot = 0;
        if (kind == 1) rxData = 1'b0;
        else if (kind == 2) rxData = 1'b1;
        else rxData = srcDef[7 - ((idx + srcOff) % srcLen)];
        for (int k = 0; k < errCount; k++)
          if (i == 50 + k * 40) rxData = ~rxData;
        idx++;
      end
    end
    @(negedge clk);
    bitEn = 0;
    fSlot = 0;
  endtask

  task automatic setCfg(input logic [7:0] up, input logic [7:0] dn, input logic [5:0] len);
    @(negedge clk);
    lenCtl = len ^ 6'h3F;
    @(negedge clk);
    upCode = up; downCode = dn; lenCtl = len;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic clearStat();
    @(negedge clk);
    clrStatus = 1;
    @(negedge clk);
    clrStatus = 0;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    expect2(0, 0, "R1 reset state");

    // up = 10000 (len code 4), down = 100 (len code 2)
    setCfg(8'h80, 8'h80, {3'd4, 3'd2});
    srcDef = 8'h80; srcLen = 5; srcOff = 0;
    driveBits(WIN, 0, 0, 0, 0, 0);
    expect2(1, 0, "R11 R2 up code clean");
    clearStat();
    expect2(0, 0, "R9 clear");

    setCfg(8'h80, 8'h80, {3'd4, 3'd2});
    srcDef = 8'h80; srcLen = 3; srcOff = 2;
    driveBits(WIN, 0, 0, 0, 1, 0);
    expect2(0, 1, "R12 R4 down code with gaps and offset");
    driveBits(WIN, 0, 0, 0, 0, 1);
    expect2(0, 1, "R9 sticky across zero window");
    clearStat();
    expect2(0, 0, "R9 clear after sticky");

    setCfg(8'h80, 8'h80, {3'd4, 3'd2});
    srcDef = 8'h80; srcLen = 5; srcOff = 3;
    driveBits(WIN, 0, 0, 1, 0, 0);
    expect2(1, 0, "R8 framed stream");
    clearStat();

    setCfg(8'h80, 8'h80, {3'd4, 3'd2});
    srcOff = 1;
    driveBits(WIN, 0, 4, 0, 0, 0);
    expect2(1, 0, "R5 four errors tolerated");
    clearStat();

    setCfg(8'h80, 8'h80, {3'd4, 3'd2});
    driveBits(WIN, 0, 6, 0, 0, 0);
    expect2(0, 0, "R6 six errors rejected");

    // up = 1 (len code 0), down = 10100101 (len code 7)
    setCfg(8'h80, 8'hA5, {3'd0, 3'd7});
    driveBits(WIN, 0, 0, 0, 0, 2);
    expect2(1, 0, "R2 one-bit code all ones");
    clearStat();
    setCfg(8'h80, 8'hA5, {3'd0, 3'd7});
    srcDef = 8'hA5; srcLen = 8; srcOff = 5;
    driveBits(WIN, 0, 0, 0, 0, 0);
    expect2(0, 1, "R2 eight-bit code");
    clearStat();
    setCfg(8'h80, 8'hA5, {3'd0, 3'd7});
    driveBits(WIN, 0, 0, 0, 0, 1);
    expect2(0, 0, "R7 zeros are not a rotation");

    // restart mid-window
    setCfg(8'h80, 8'h80, {3'd4, 3'd2});
    srcDef = 8'h80; srcLen = 5; srcOff = 0;
    driveBits(300, 0, 0, 0, 0, 0);
    setCfg(8'h80, 8'hC0, {3'd4, 3'd2});
    driveBits(WIN - 1, 300, 0, 0, 0, 0);
    expect2(0, 0, "R10 restart delays decision");
    driveBits(1, 300 + WIN - 1, 0, 0, 0, 0);
    expect2(1, 0, "R3 decision on last window bit");

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule